// File: doc/BRIEF.md
# Acknowledge-Pending Coalescing Tracker

This block follows a single edge-triggered interrupt line after it has been delivered. It records which destinations took the most recent delivery and have not yet sent an end-of-interrupt (EOI), and it keeps a count of those outstanding acknowledgements. While the count is above zero, a fresh assertion of the line would merge with the unacknowledged one. The `coalesce` output tells software and the delivery path this, so the new edge can be reported as merged and held back.

The delivery path reports each delivery with the bitmap of destinations that accepted it and a signed acceptance result. Destinations report EOIs one at a time. Two restore paths bring the record back in line with the destinations' own view of what is still pending. A full resync replaces the whole record. A single-destination restore adjusts one bit. A bulk-clear input empties the record when saved state is about to be re-injected. Delivery itself happens outside this block.

Top module: `ack_track`

## Requirements
- R1: After a cycle with `rst` high, `pend_map` is all zeros, `pend_cnt` is 0 and `coalesce` is 0.
- R2: `coalesce` is 1 exactly when `pend_cnt` is nonzero.
- R3: A delivery loads `pend_map` with `dlv_map`. It loads `pend_cnt` with `dlv_result`, limited to NDEST, so the count never exceeds NDEST.
- R4: A delivery whose `dlv_result` is negative sets `pend_cnt` to 0. `pend_map` still takes `dlv_map`.
- R5: An EOI whose index selects a set bit clears that bit and lowers `pend_cnt` by one.
- R6: An EOI whose index selects a clear bit, or whose index is NDEST or above, changes nothing.
- R7: An EOI or a single restore that would lower `pend_cnt` below zero instead loads `pend_map` with `resync_view` and `pend_cnt` with the number of ones in `resync_view`.
- R8: A single restore compares `one_pending` with bit `one_dest` of `pend_map`. If they are equal, or the index is NDEST or above, nothing changes. If they differ, the bit takes `one_pending` and `pend_cnt` moves by one. An increase stops at NDEST.
- R9: A resync request loads `pend_map` with `resync_view` and `pend_cnt` with its number of ones.
- R10: A bulk clear empties `pend_map` and sets `pend_cnt` to 0.
- R11: Only one operation acts in a cycle. The order, highest first, is bulk clear, resync, delivery, single restore, EOI. Any lower request in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bulk_clr | input | 1 | Empty the record before re-injecting saved state |
| resync_req | input | 1 | Rebuild the record from `resync_view` |
| resync_view | input | NDEST | Current per-destination pending view |
| dlv_valid | input | 1 | A delivery of the tracked line took place |
| dlv_map | input | NDEST | Destinations that accepted the delivery |
| dlv_result | input | CNT_W+1 | Signed acceptance result; negative means failure |
| one_valid | input | 1 | Single-destination restore request |
| one_dest | input | IDX_W | Destination index for the restore |
| one_pending | input | 1 | That destination's current pending state |
| eoi_valid | input | 1 | An EOI from one destination |
| eoi_dest | input | IDX_W | Index of the destination sending the EOI |
| pend_map | output | NDEST | Destinations still owing an EOI |
| pend_cnt | output | CNT_W | Outstanding acknowledgement count |
| coalesce | output | 1 | A new assertion would be merged |

## Verification
The bench builds the tracker with NDEST set to 5. At that size the 3-bit destination indices 5 to 7 exist, so out-of-range EOIs and restores can be exercised. The 4-bit signed result can then exceed NDEST (up to 7) or be negative, which reaches both the clamp and the zero case. A delivery whose result is below the number of accepting destinations lets later EOIs drive the count toward zero while bits are still set, which reaches the rebuild path. A full record combined with a restore that sets a bit reaches the increment limit.

// File: rtl/ack_track_pkg.sv
package ack_track_pkg;

    // One operation acts per cycle; the order below is the priority order.
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_BULK   = 3'd1,
        OP_RESYNC = 3'd2,
        OP_DLV    = 3'd3,
        OP_ONE    = 3'd4,
        OP_EOI    = 3'd5
    } op_e;

    typedef struct packed {
        logic bulk;
        logic resync;
        logic dlv;
        logic one;
        logic eoi;
    } req_t;

    function automatic op_e pick_op(req_t r);
        op_e o;
        if (r.bulk)        o = OP_BULK;
        else if (r.resync) o = OP_RESYNC;
        else if (r.dlv)    o = OP_DLV;
        else if (r.one)    o = OP_ONE;
        else if (r.eoi)    o = OP_EOI;
        else               o = OP_IDLE;
        return o;
    endfunction

endpackage

// File: rtl/ack_track_popcnt.sv
module ack_track_popcnt #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/ack_track_dec.sv
module ack_track_dec #(
    parameter int NDEST = 16,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [NDEST-1:0] hot
);
    // Indices at or above NDEST produce an all-zero vector.
    for (genvar g = 0; g < NDEST; g++) begin : g_bit
        assign hot[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/ack_track_next.sv
module ack_track_next
    import ack_track_pkg::*;
#(
    parameter int NDEST = 16,
    parameter int CNT_W = 5
) (
    input  op_e                     op,
    input  logic [NDEST-1:0]        cur_map,
    input  logic [CNT_W-1:0]        cur_cnt,
    input  logic [NDEST-1:0]        view_map,
    input  logic [CNT_W-1:0]        view_cnt,
    input  logic [NDEST-1:0]        dlv_map,
    input  logic signed [CNT_W:0]   dlv_result,
    input  logic [NDEST-1:0]        one_hot,
    input  logic                    one_pending,
    input  logic [NDEST-1:0]        eoi_hot,
    output logic [NDEST-1:0]        nxt_map,
    output logic [CNT_W-1:0]        nxt_cnt
);
    localparam logic [CNT_W-1:0]      CNT_MAX  = CNT_W'(NDEST);
    localparam logic signed [CNT_W:0] RES_MAX  = $signed({1'b0, CNT_MAX});

    logic one_bit;
    logic eoi_bit;
    logic underflow;

    assign one_bit = |(cur_map & one_hot);
    assign eoi_bit = |(cur_map & eoi_hot);

    always_comb begin
        nxt_map   = cur_map;
        nxt_cnt   = cur_cnt;
        underflow = 1'b0;
        unique case (op)
            OP_BULK: begin
                nxt_map = '0;
                nxt_cnt = '0;
            end
            OP_RESYNC: begin
                nxt_map = view_map;
                nxt_cnt = view_cnt;
            end
            OP_DLV: begin
                nxt_map = dlv_map;
                if (dlv_result[CNT_W])
                    nxt_cnt = '0;
                else if (dlv_result > RES_MAX)
                    nxt_cnt = CNT_MAX;
                else
                    nxt_cnt = dlv_result[CNT_W-1:0];
            end
            OP_ONE: begin
                if (|one_hot) begin
                    if (one_pending && !one_bit) begin
                        nxt_map = cur_map | one_hot;
                        if (cur_cnt != CNT_MAX)
                            nxt_cnt = cur_cnt + 1'b1;
                    end else if (!one_pending && one_bit) begin
                        if (cur_cnt == '0) begin
                            underflow = 1'b1;
                        end else begin
                            nxt_map = cur_map & ~one_hot;
                            nxt_cnt = cur_cnt - 1'b1;
                        end
                    end
                end
            end
            OP_EOI: begin
                if (eoi_bit) begin
                    if (cur_cnt == '0) begin
                        underflow = 1'b1;
                    end else begin
                        nxt_map = cur_map & ~eoi_hot;
                        nxt_cnt = cur_cnt - 1'b1;
                    end
                end
            end
            default: ;
        endcase
        if (underflow) begin
            nxt_map = view_map;
            nxt_cnt = view_cnt;
        end
    end
endmodule

// File: rtl/ack_track.sv
module ack_track
    import ack_track_pkg::*;
#(
    parameter int NDEST = 16,
    parameter int CNT_W = $clog2(NDEST + 1),
    parameter int IDX_W = $clog2(NDEST)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bulk_clr,
    input  logic                   resync_req,
    input  logic [NDEST-1:0]       resync_view,
    input  logic                   dlv_valid,
    input  logic [NDEST-1:0]       dlv_map,
    input  logic signed [CNT_W:0]  dlv_result,
    input  logic                   one_valid,
    input  logic [IDX_W-1:0]       one_dest,
    input  logic                   one_pending,
    input  logic                   eoi_valid,
    input  logic [IDX_W-1:0]       eoi_dest,
    output logic [NDEST-1:0]       pend_map,
    output logic [CNT_W-1:0]       pend_cnt,
    output logic                   coalesce
);
    req_t             req;
    op_e              op;
    logic [NDEST-1:0] map_q, map_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] view_cnt;
    logic [NDEST-1:0] one_hot, eoi_hot;

    assign req = '{bulk: bulk_clr, resync: resync_req, dlv: dlv_valid,
                   one: one_valid, eoi: eoi_valid};
    assign op  = pick_op(req);

    ack_track_popcnt #(.W(NDEST), .CW(CNT_W)) u_pop (
        .vec  (resync_view),
        .ones (view_cnt)
    );

    ack_track_dec #(.NDEST(NDEST), .IDX_W(IDX_W)) u_dec_one (
        .idx (one_dest),
        .hot (one_hot)
    );

    ack_track_dec #(.NDEST(NDEST), .IDX_W(IDX_W)) u_dec_eoi (
        .idx (eoi_dest),
        .hot (eoi_hot)
    );

    ack_track_next #(.NDEST(NDEST), .CNT_W(CNT_W)) u_next (
        .op          (op),
        .cur_map     (map_q),
        .cur_cnt     (cnt_q),
        .view_map    (resync_view),
        .view_cnt    (view_cnt),
        .dlv_map     (dlv_map),
        .dlv_result  (dlv_result),
        .one_hot     (one_hot),
        .one_pending (one_pending),
        .eoi_hot     (eoi_hot),
        .nxt_map     (map_d),
        .nxt_cnt     (cnt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
            cnt_q <= '0;
        end else begin
            map_q <= map_d;
            cnt_q <= cnt_d;
        end
    end

    assign pend_map = map_q;
    assign pend_cnt = cnt_q;
    assign coalesce = (cnt_q != '0);
endmodule

// File: rtl/ack_track_chk.sv
module ack_track_chk #(
    parameter int NDEST = 16,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bulk_clr,
    input logic                  resync_req,
    input logic [NDEST-1:0]      resync_view,
    input logic                  dlv_valid,
    input logic signed [CNT_W:0] dlv_result,
    input logic                  one_valid,
    input logic                  eoi_valid,
    input logic [IDX_W-1:0]      eoi_dest,
    input logic [NDEST-1:0]      pend_map,
    input logic [CNT_W-1:0]      pend_cnt,
    input logic                  coalesce
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NDEST);
    localparam logic [IDX_W:0]   IDX_LIM = (IDX_W+1)'(NDEST);

    logic eoi_only;
    logic eoi_in_range;
    assign eoi_only     = eoi_valid && !bulk_clr && !resync_req && !dlv_valid && !one_valid;
    assign eoi_in_range = {1'b0, eoi_dest} < IDX_LIM;

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (pend_cnt == '0 && pend_map == '0 && !coalesce));

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= CNT_MAX);

    assert_neg_result_R4: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !bulk_clr && !resync_req && dlv_result < 0) |=> pend_cnt == '0);

    assert_eoi_dec_R5: assert property (@(posedge clk) disable iff (rst)
        (eoi_only && eoi_in_range && pend_map[eoi_dest] && pend_cnt != '0)
        |=> pend_cnt == $past(pend_cnt) - 1'b1);

    assert_eoi_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (eoi_only && (!eoi_in_range || !pend_map[eoi_dest]))
        |=> ($stable(pend_map) && $stable(pend_cnt)));

    assert_resync_map_R9: assert property (@(posedge clk) disable iff (rst)
        (resync_req && !bulk_clr) |=> pend_map == $past(resync_view));

    assert_bulk_empty_R10: assert property (@(posedge clk) disable iff (rst)
        bulk_clr |=> (pend_map == '0 && pend_cnt == '0));
endmodule

bind ack_track ack_track_chk #(.NDEST(NDEST), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bulk_clr    (bulk_clr),
    .resync_req  (resync_req),
    .resync_view (resync_view),
    .dlv_valid   (dlv_valid),
    .dlv_result  (dlv_result),
    .one_valid   (one_valid),
    .eoi_valid   (eoi_valid),
    .eoi_dest    (eoi_dest),
    .pend_map    (pend_map),
    .pend_cnt    (pend_cnt),
    .coalesce    (coalesce)
);

// File: tb/tb_ack_track.sv
module tb_ack_track;
    localparam int N  = 5;
    localparam int CW = $clog2(N + 1);
    localparam int IW = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 bulk_clr, resync_req, dlv_valid, one_valid, one_pending, eoi_valid;
    logic [N-1:0]         resync_view, dlv_map;
    logic signed [CW:0]   dlv_result;
    logic [IW-1:0]        one_dest, eoi_dest;
    logic [N-1:0]         pend_map;
    logic [CW-1:0]        pend_cnt;
    logic                 coalesce;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [N-1:0] m_map;
    int         m_cnt;

    always #5 clk = ~clk;

    ack_track #(.NDEST(N)) dut (
        .clk(clk), .rst(rst), .bulk_clr(bulk_clr), .resync_req(resync_req),
        .resync_view(resync_view), .dlv_valid(dlv_valid), .dlv_map(dlv_map),
        .dlv_result(dlv_result), .one_valid(one_valid), .one_dest(one_dest),
        .one_pending(one_pending), .eoi_valid(eoi_valid), .eoi_dest(eoi_dest),
        .pend_map(pend_map), .pend_cnt(pend_cnt), .coalesce(coalesce)
    );

    function automatic int ones(bit [N-1:0] v);
        int s = 0;
        for (int i = 0; i < N; i++) s += v[i];
        return s;
    endfunction

    // Behavioural reference of the requirement list.
    task automatic model_update();
        int d, r;
        if (rst) begin
            m_map = '0; m_cnt = 0;
        end else if (bulk_clr) begin
            m_map = '0; m_cnt = 0;
        end else if (resync_req) begin
            m_map = resync_view; m_cnt = ones(resync_view);
        end else if (dlv_valid) begin
            r = dlv_result;
            m_map = dlv_map;
            m_cnt = (r < 0) ? 0 : ((r > N) ? N : r);
        end else if (one_valid) begin
            d = one_dest;
            if (d < N) begin
                if (one_pending && !m_map[d]) begin
                    m_map[d] = 1'b1;
                    if (m_cnt < N) m_cnt++;
                end else if (!one_pending && m_map[d]) begin
                    if (m_cnt == 0) begin
                        m_map = resync_view; m_cnt = ones(resync_view);
                    end else begin
                        m_map[d] = 1'b0; m_cnt--;
                    end
                end
            end
        end else if (eoi_valid) begin
            d = eoi_dest;
            if (d < N && m_map[d]) begin
                if (m_cnt == 0) begin
                    m_map = resync_view; m_cnt = ones(resync_view);
                end else begin
                    m_map[d] = 1'b0; m_cnt--;
                end
            end
        end
    endtask

    task automatic check(string tag);
        checks++;
        if (pend_map !== m_map || int'(pend_cnt) != m_cnt || coalesce !== (m_cnt != 0)) begin
            errors++;
            $display("FAIL %s: map=%b cnt=%0d co=%b expected map=%b cnt=%0d co=%b",
                     tag, pend_map, pend_cnt, coalesce, m_map, m_cnt, (m_cnt != 0));
        end
    endtask

    task automatic idle_inputs();
        rst = 0; bulk_clr = 0; resync_req = 0; dlv_valid = 0; one_valid = 0;
        eoi_valid = 0; one_pending = 0; dlv_map = '0; dlv_result = '0;
        one_dest = '0; eoi_dest = '0;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_update();
        #2;
        check(tag);
        idle_inputs();
    endtask

    task automatic deliver(bit [N-1:0] m, int r, string tag);
        dlv_valid = 1; dlv_map = m; dlv_result = (CW+1)'(r);
        step(tag);
    endtask

    task automatic eoi(int d, string tag);
        eoi_valid = 1; eoi_dest = IW'(d);
        step(tag);
    endtask

    task automatic restore(int d, bit p, string tag);
        one_valid = 1; one_dest = IW'(d); one_pending = p;
        step(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        resync_view = '0;
        m_map = '0; m_cnt = 0;
        #2;
        rst = 1;
        step("R1 reset");
        step("R1 idle after reset");

        deliver(5'b10110, 3, "R3 delivery load");
        eoi(1, "R5 eoi on set bit");
        eoi(1, "R6 eoi on clear bit");
        eoi(6, "R6 eoi out of range");
        eoi(2, "R5 second eoi");
        eoi(4, "R2 last eoi drops coalesce");
        deliver(5'b11111, 7, "R3 result clamp");
        deliver(5'b00011, -1, "R4 negative result");

        resync_view = 5'b01001;
        eoi(0, "R7 eoi underflow rebuild");
        restore(4, 1, "R8 restore sets bit");
        restore(4, 1, "R8 restore equal no change");
        restore(0, 0, "R8 restore clears bit");
        restore(7, 1, "R8 restore out of range");
        deliver(5'b00000, 5, "R3 count without bits");
        restore(2, 1, "R8 restore increment limit");
        deliver(5'b00011, 1, "R3 short result");
        eoi(0, "R5 eoi to zero");
        resync_view = 5'b10100;
        restore(1, 0, "R7 restore underflow rebuild");

        resync_view = 5'b11111;
        resync_req = 1;
        step("R9 resync");

        dlv_valid = 1; dlv_map = 5'b00001; dlv_result = 1; eoi_valid = 1; eoi_dest = 0;
        step("R11 delivery beats eoi");
        dlv_valid = 1; dlv_map = 5'b00110; dlv_result = 2; one_valid = 1; one_dest = 0; one_pending = 1;
        step("R11 delivery beats restore");
        resync_view = 5'b01010;
        resync_req = 1; dlv_valid = 1; dlv_map = 5'b11111; dlv_result = 5;
        step("R11 resync beats delivery");
        bulk_clr = 1; resync_req = 1; dlv_valid = 1; dlv_map = 5'b11111; dlv_result = 5;
        eoi_valid = 1; eoi_dest = 1;
        step("R10 R11 bulk clear wins");
        deliver(5'b11000, 2, "R3 before bulk");
        bulk_clr = 1;
        step("R10 bulk clear");

        for (int k = 0; k < 600; k++) begin
            resync_view = N'($urandom);
            bulk_clr    = ($urandom % 40) == 0;
            resync_req  = ($urandom % 20) == 0;
            dlv_valid   = ($urandom % 5) == 0;
            dlv_map     = N'($urandom);
            dlv_result  = (CW+1)'($urandom);
            one_valid   = ($urandom % 4) == 0;
            one_dest    = IW'($urandom);
            one_pending = 1'($urandom);
            eoi_valid   = ($urandom % 2) == 0;
            eoi_dest    = IW'($urandom);
            rst         = ($urandom % 200) == 0;
            step("R11 random mix");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule